// File: doc/BRIEF.md
# Privilege Mode and Stack-Pointer Control

This block keeps the system half of a processor status word and decides at each cycle whether the core runs at the high (supervisor) or the low (user) privilege level. It holds the trace enable, the supervisor flag and the interrupt priority mask. It accepts writes to that half-word from the instruction path, but only while in supervisor mode. Exception entry always forces supervisor mode. The old value is kept on a port so the exception sequencer can stack it.

The block also owns the two physical copies of the stack pointer. Reads and writes of the architectural stack pointer go to the user copy when the supervisor flag is clear and to the supervisor copy when it is set. It drives the three-bit bus function code for each access. It raises a one-cycle privilege-violation request when user code tries a privileged operation. It raises a one-cycle trace request after each completed instruction while tracing is on.

Top module: `priv_mode_ctl`

## Requirements
- R1: While reset is active and on the first cycle after it, super_mode is 1 and sys_byte equals 8'h27: trace bit 7 clear, supervisor bit 5 set, mask bits 2:0 all ones. Both stack-pointer copies read 0, and priv_trap and trace_trap are 0.
- R2: In supervisor mode, sr_wr loads sys_byte on the next edge with sr_wdata & 8'hA7. Bit 7 is trace, bit 5 is supervisor, bits 2:0 are the mask, and bits 6, 4 and 3 always read 0. Clearing bit 5 this way enters user mode.
- R3: In user mode, sr_wr leaves sys_byte unchanged and priv_trap is 1 on the following cycle.
- R4: priv_exec in user mode makes priv_trap 1 for exactly the following cycle. In supervisor mode, priv_exec never raises it.
- R5: exc_take sets bit 5 and clears bit 7 on the next edge, keeps the mask, and loads saved_sys with the value held before the edge. It takes priority over a write in the same cycle.
- R6: sp_sel equals super_mode. sp_rdata returns the supervisor copy when it is 1 and the user copy when it is 0. sp_wr writes sp_wdata into the currently selected copy only.
- R7: instr_done while bit 7 of sys_byte is 1 makes trace_trap 1 for the following cycle. With bit 7 clear, trace_trap stays 0.
- R8: fc is 3'b111 when acc_iack is 1. Otherwise it is 3'b001 for user data, 3'b010 for user program, 3'b101 for supervisor data and 3'b110 for supervisor program (acc_prog selects program). fc[2] always equals the mode outside acknowledge cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_take | input | 1 | Exception entry (trap or interrupt) this cycle |
| sr_wr | input | 1 | Write request to the system byte |
| sr_wdata | input | 8 | Data for the system byte |
| priv_exec | input | 1 | A privileged instruction is being executed |
| instr_done | input | 1 | Instruction-complete strobe |
| acc_prog | input | 1 | Current access is a program fetch (else data) |
| acc_iack | input | 1 | Current access is an interrupt acknowledge |
| sp_wr | input | 1 | Write to the architectural stack pointer |
| sp_wdata | input | SP_W | Stack-pointer write data |
| super_mode | output | 1 | 1 in supervisor mode |
| sys_byte | output | 8 | Current system byte |
| saved_sys | output | 8 | System byte captured at last exception entry |
| fc | output | 3 | Bus function code |
| sp_sel | output | 1 | Stack-pointer copy in use (1 = supervisor) |
| sp_rdata | output | SP_W | Active stack-pointer value |
| priv_trap | output | 1 | Privilege-violation trap request |
| trace_trap | output | 1 | Trace trap request |

## Verification
The properties assume that acc_prog and acc_iack are never both meaningful in a way that changes the expected code. Acknowledge always wins, so the bench drives both freely. They also assume that each strobe is a single-cycle level sampled at the edge, with no handshake. The random stimulus draws each strobe independently every cycle. It keeps exceptions rare and writes frequent, so that long stretches of user mode occur and blocked writes and privileged operations are exercised there.

// File: rtl/priv_mode_pkg.sv
package priv_mode_pkg;
   typedef struct packed {
      logic       trace;
      logic       rsv6;
      logic       sup;
      logic [1:0] rsv43;
      logic [2:0] imask;
   } sys_t;

   localparam logic [7:0] SYS_WMASK = 8'hA7;

   localparam logic [2:0] FC_UDATA = 3'b001;
   localparam logic [2:0] FC_UPROG = 3'b010;
   localparam logic [2:0] FC_SDATA = 3'b101;
   localparam logic [2:0] FC_SPROG = 3'b110;
   localparam logic [2:0] FC_IACK  = 3'b111;
endpackage

// File: rtl/priv_sysreg.sv
module priv_sysreg
   import priv_mode_pkg::*;
#(
   parameter logic [2:0] RST_MASK = 3'b111
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       exc_take,
   input  logic       sr_wr,
   input  logic [7:0] sr_wdata,
   output sys_t       sys_q,
   output sys_t       saved_q
);
   localparam sys_t RST_SYS = '{trace: 1'b0, rsv6: 1'b0, sup: 1'b1,
                                rsv43: 2'b00, imask: RST_MASK};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sys_q   <= RST_SYS;
         saved_q <= RST_SYS;
      end else if (exc_take) begin
         saved_q     <= sys_q;
         sys_q.sup   <= 1'b1;
         sys_q.trace <= 1'b0;
      end else if (sr_wr && sys_q.sup) begin
         sys_q <= sys_t'(sr_wdata & SYS_WMASK);
      end
   end
endmodule

// File: rtl/priv_spbank.sv
module priv_spbank #(
   parameter int SP_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sel,
   input  logic            wr,
   input  logic [SP_W-1:0] wdata,
   output logic [SP_W-1:0] rdata
);
   localparam int NCOPY = 2;

   logic [SP_W-1:0] copy_q [NCOPY];

   for (genvar i = 0; i < NCOPY; i++) begin : g_copy
      always_ff @(posedge clk) begin
         if (!rst_n)
            copy_q[i] <= '0;
         else if (wr && (int'(sel) == i))
            copy_q[i] <= wdata;
      end
   end

   assign rdata = copy_q[sel];
endmodule

// File: rtl/priv_fcgen.sv
module priv_fcgen
   import priv_mode_pkg::*;
(
   input  logic       sup,
   input  logic       prog,
   input  logic       iack,
   output logic [2:0] fc
);
   always_comb begin
      if (iack)
         fc = FC_IACK;
      else if (sup)
         fc = prog ? FC_SPROG : FC_SDATA;
      else
         fc = prog ? FC_UPROG : FC_UDATA;
   end
endmodule

// File: rtl/priv_traps.sv
module priv_traps (
   input  logic clk,
   input  logic rst_n,
   input  logic sup,
   input  logic trace_on,
   input  logic sr_wr,
   input  logic priv_exec,
   input  logic instr_done,
   output logic priv_trap,
   output logic trace_trap
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         priv_trap  <= 1'b0;
         trace_trap <= 1'b0;
      end else begin
         priv_trap  <= !sup && (sr_wr || priv_exec);
         trace_trap <= trace_on && instr_done;
      end
   end
endmodule

// File: rtl/priv_mode_ctl.sv
module priv_mode_ctl
   import priv_mode_pkg::*;
#(
   parameter int         SP_W     = 32,
   parameter logic [2:0] RST_MASK = 3'b111
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            exc_take,
   input  logic            sr_wr,
   input  logic [7:0]      sr_wdata,
   input  logic            priv_exec,
   input  logic            instr_done,
   input  logic            acc_prog,
   input  logic            acc_iack,
   input  logic            sp_wr,
   input  logic [SP_W-1:0] sp_wdata,
   output logic            super_mode,
   output logic [7:0]      sys_byte,
   output logic [7:0]      saved_sys,
   output logic [2:0]      fc,
   output logic            sp_sel,
   output logic [SP_W-1:0] sp_rdata,
   output logic            priv_trap,
   output logic            trace_trap
);
   if (SP_W < 16 || SP_W > 64) begin : g_bad_width
      $error("priv_mode_ctl: SP_W must lie in 16..64");
   end

   sys_t sys_q, saved_q;

   priv_sysreg #(.RST_MASK(RST_MASK)) u_sys (
      .clk(clk), .rst_n(rst_n), .exc_take(exc_take),
      .sr_wr(sr_wr), .sr_wdata(sr_wdata),
      .sys_q(sys_q), .saved_q(saved_q));

   priv_spbank #(.SP_W(SP_W)) u_sp (
      .clk(clk), .rst_n(rst_n), .sel(sys_q.sup), .wr(sp_wr),
      .wdata(sp_wdata), .rdata(sp_rdata));

   priv_fcgen u_fc (
      .sup(sys_q.sup), .prog(acc_prog), .iack(acc_iack), .fc(fc));

   priv_traps u_trap (
      .clk(clk), .rst_n(rst_n), .sup(sys_q.sup), .trace_on(sys_q.trace),
      .sr_wr(sr_wr), .priv_exec(priv_exec), .instr_done(instr_done),
      .priv_trap(priv_trap), .trace_trap(trace_trap));

   assign super_mode = sys_q.sup;
   assign sp_sel     = sys_q.sup;
   assign sys_byte   = sys_q;
   assign saved_sys  = saved_q;
endmodule

// File: rtl/priv_mode_chk.sv
module priv_mode_chk #(
   parameter int SP_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            exc_take,
   input logic            sr_wr,
   input logic            priv_exec,
   input logic            instr_done,
   input logic            acc_iack,
   input logic            sp_wr,
   input logic            super_mode,
   input logic [7:0]      sys_byte,
   input logic [2:0]      fc,
   input logic            sp_sel,
   input logic [SP_W-1:0] sp_rdata,
   input logic            priv_trap,
   input logic            trace_trap
);
   a_r1_reset_super: assert property (@(posedge clk)
      !rst_n |=> super_mode && !priv_trap && !trace_trap);

   a_r3_user_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (!super_mode && sr_wr && !exc_take) |=> $stable(sys_byte) && priv_trap);

   a_r4_priv_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (!super_mode && priv_exec) |=> priv_trap);

   a_r4_no_trap_super: assert property (@(posedge clk) disable iff (!rst_n)
      super_mode |=> !priv_trap);

   a_r5_exc_enters_super: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |=> super_mode && !sys_byte[7]);

   a_r6_sp_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
      sp_sel == super_mode);

   a_r6_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sp_wr && !exc_take && !sr_wr) |=> $stable(sp_rdata));

   a_r7_trace: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_done && sys_byte[7]) |=> trace_trap);

   a_r8_fc_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_iack |-> (fc[2] == super_mode) && (fc[1:0] != 2'b00) && (fc[1:0] != 2'b11));
endmodule

bind priv_mode_ctl priv_mode_chk #(.SP_W(SP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .sr_wr(sr_wr),
   .priv_exec(priv_exec), .instr_done(instr_done), .acc_iack(acc_iack),
   .sp_wr(sp_wr), .super_mode(super_mode), .sys_byte(sys_byte), .fc(fc),
   .sp_sel(sp_sel), .sp_rdata(sp_rdata), .priv_trap(priv_trap),
   .trace_trap(trace_trap));

// File: tb/sim_priv_mode_ctl.sv
`timescale 1ns/1ps
module sim_priv_mode_ctl;
   localparam int SP_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic exc_take = 0, sr_wr = 0, priv_exec = 0, instr_done = 0;
   logic acc_prog = 0, acc_iack = 0, sp_wr = 0;
   logic [7:0] sr_wdata = '0;
   logic [SP_W-1:0] sp_wdata = '0;
   logic super_mode, sp_sel, priv_trap, trace_trap;
   logic [7:0] sys_byte, saved_sys;
   logic [2:0] fc;
   logic [SP_W-1:0] sp_rdata;

   always #10 clk = ~clk;

   priv_mode_ctl #(.SP_W(SP_W)) u0 (.*);

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   logic [7:0] m_sys, m_saved;
   logic [SP_W-1:0] m_usp, m_ssp;
   logic m_ptrap, m_ttrap;

   task automatic chk(string req, logic [SP_W-1:0] act, logic [SP_W-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] exp_fc(logic s, logic prog, logic iack);
      if (iack) return 3'b111;
      return {s, prog, !prog};
   endfunction

   task automatic check_regs();
      chk("R2/R3/R5 sys_byte", SP_W'(sys_byte), SP_W'(m_sys));
      chk("R5 saved_sys", SP_W'(saved_sys), SP_W'(m_saved));
      chk("R3/R4 priv_trap", SP_W'(priv_trap), SP_W'(m_ptrap));
      chk("R7 trace_trap", SP_W'(trace_trap), SP_W'(m_ttrap));
      chk("R6 sp_sel", SP_W'(sp_sel), SP_W'(m_sys[5]));
   endtask

   task automatic step(logic e, logic w, logic [7:0] wd, logic pe, logic id,
                       logic pr, logic ia, logic sw, logic [SP_W-1:0] sd);
      exc_take = e; sr_wr = w; sr_wdata = wd; priv_exec = pe; instr_done = id;
      acc_prog = pr; acc_iack = ia; sp_wr = sw; sp_wdata = sd;
      #1;
      chk("R8 fc", SP_W'(fc), SP_W'(exp_fc(m_sys[5], pr, ia)));
      chk("R6 sp_rdata", sp_rdata, m_sys[5] ? m_ssp : m_usp);
      m_ptrap = !m_sys[5] && (w || pe);
      m_ttrap = m_sys[7] && id;
      if (sw) begin
         if (m_sys[5]) m_ssp = sd; else m_usp = sd;
      end
      if (e) begin
         m_saved = m_sys;
         m_sys[5] = 1'b1;
         m_sys[7] = 1'b0;
      end else if (w && m_sys[5]) begin
         m_sys = wd & 8'hA7;
      end
      @(negedge clk);
      check_regs();
   endtask

   initial begin
      #(20.0 * 200000);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_sys = 8'h27; m_saved = 8'h27; m_usp = '0; m_ssp = '0;
      m_ptrap = 0; m_ttrap = 0;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 super_mode", SP_W'(super_mode), 1);
      chk("R1 sys_byte", SP_W'(sys_byte), 32'h27);
      chk("R1 sp_rdata", sp_rdata, 0);
      chk("R1 traps", SP_W'({priv_trap, trace_trap}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_regs();
      // R6: supervisor copy written, then R2 drop to user with reserved bits set
      step(0,0,8'h00,0,0,0,0,1,32'h0000_4000);
      step(0,1,8'h5A,0,0,1,0,0,'0);
      chk("R2 user entered", SP_W'(super_mode), 0);
      // R6: user copy is separate
      step(0,0,8'h00,0,0,0,0,1,32'h0000_1230);
      // R3: blocked user write tries to regain supervisor
      step(0,1,8'hFF,0,0,0,0,0,'0);
      chk("R3 still user", SP_W'(super_mode), 0);
      // R4: privileged instruction in user mode, then a quiet cycle
      step(0,0,8'h00,1,0,0,0,0,'0);
      step(0,0,8'h00,0,0,0,1,0,'0);
      chk("R4 single pulse", SP_W'(priv_trap), 0);
      // R5: exception together with a write
      step(1,1,8'h00,0,0,1,0,0,'0);
      chk("R5 super after exc", SP_W'(super_mode), 1);
      chk("R6 ssp back", sp_rdata, 32'h0000_4000);
      // R7: tracing on, instruction completes
      step(0,1,8'hA3,0,0,0,0,0,'0);
      step(0,0,8'h00,0,1,0,0,0,'0);
      chk("R7 trace pulse", SP_W'(trace_trap), 1);
      step(1,0,8'h00,0,1,0,0,0,'0);
      // R4: privileged op in supervisor mode gives nothing
      step(0,0,8'h00,1,0,0,0,0,'0);
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[2:0] == 3'd0, r[4:3] == 2'd0, 8'($urandom), r[5] & r[6],
              r[7], r[8], r[11:9] == 3'd0, r[12], $urandom);
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule